// File: doc/BRIEF.md
# Regulator Plane Fault Guard

This block takes the digital comparator flags of a multiphase core regulator plane and a single-phase north-bridge plane. For each plane it qualifies and latches faults, turns each latched fault into a gate-control override for that plane's drivers, and produces one combined power-good output. Overcurrent is qualified on two tiers. A normal overload flag must persist for a long window before it latches. A short-circuit flag, whose threshold is set higher, latches after a much shorter window. An overvoltage flag latches on the first clock edge that sees it.

The two planes keep separate latches, so a fault on one plane changes only that plane's gate override. A latched overcurrent of either kind turns every switch of the plane off. A latched overvoltage turns the low-side switches on and the high-side switches off, which clamps the output. The latches hold until the supply-ready input or the enable input goes low. Each plane reports which fault type latched first. All delays are counted in clock cycles.

Top module: `vr_fault_guard`

## Requirements
- R1: While `rst` is high, or while `por_ok` or `en` is low, every plane's fault kind reads 0 (none), every gate code reads 1 (all off) and `pgood` is 0. Fault kind codes are 0 none, 1 overload, 2 short circuit and 3 overvoltage. Gate codes are 0 regulate, 1 all switches off and 2 low-side on with high-side off. Plane 0 (core) uses bits [1:0] of each vector and plane 1 (north bridge) uses bits [3:2].
- R2: An overload flag that stays high for OC_DLY consecutive rising edges latches kind 1 on that edge. After OC_DLY-1 edges nothing has latched.
- R3: If the overload flag drops for even one edge, the persistence count restarts from zero.
- R4: A short-circuit flag that stays high for SC_DLY consecutive edges latches kind 2.
- R5: An overvoltage flag latches kind 3 on the first edge at which it is sampled high.
- R6: Kind 1 or 2 sets that plane's gate code to 1. Kind 3 sets it to 2. With no fault and the block active, the gate code is 0.
- R7: A fault on one plane leaves the other plane's kind and gate code unchanged.
- R8: Once a kind is latched it does not change while the block stays active, even after the flag drops or a different fault arrives. Faults that latch on the same edge take the priority overvoltage, then short circuit, then overload.
- R9: The latches clear when `en` or `por_ok` goes low. Raising the enable again leaves the block fault-free.
- R10: `pgood` is registered. One edge after the inputs settle, it is 1 only when the block is active, no plane has a latched fault, and every plane with its `plane_on` bit set has both window flags low.
- R11: A plane whose `plane_on` bit is 0 (commanded off by VID) does not affect `pgood` through its window flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supplies ready; low clears latches |
| en | input | 1 | Enable; low clears latches |
| oc_flag | input | NPL | Normal overload comparator, one bit per plane |
| sc_flag | input | NPL | Short-circuit comparator, one bit per plane |
| ov_flag | input | NPL | Overvoltage comparator, one bit per plane |
| win_hi | input | NPL | Output above power-good window |
| win_lo | input | NPL | Output below power-good window |
| plane_on | input | NPL | Plane commanded on by VID |
| gate_ovr | output | 2*NPL | Per-plane gate override code |
| fault_kind | output | 2*NPL | Per-plane first latched fault kind |
| pgood | output | 1 | Power good |

## Verification
The bench targets the edges of the qualification windows. It holds a flag for exactly one edge less than the delay and then for exactly the delay, so a counter that is off by one shows as a latch one cycle early or late. A flag that drops for a single cycle just before expiry catches a counter that pauses instead of restarting, because such a design would latch too soon. Other tests put an overvoltage on top of a latched overload and a fault on one plane only. A design that overwrites the first kind, or that shares latches between the planes, changes a code it should have left alone. Power-good is checked with a plane commanded off while its window flags are set, and across a clear by enable. A design that ignores the VID-off exemption, or that keeps a latch through the clear, leaves `pgood` low.

// File: rtl/vr_fault_pkg.sv
package vr_fault_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_OVL  = 2'd1,
    FK_SHORT = 2'd2,
    FK_OVV  = 2'd3
  } fault_kind_t;

  typedef enum logic [1:0] {
    GC_RUN    = 2'd0,
    GC_ALLOFF = 2'd1,
    GC_CLAMP  = 2'd2
  } gate_code_t;

  function automatic gate_code_t kind_to_gate(input fault_kind_t k, input logic act);
    if (!act) return GC_ALLOFF;
    case (k)
      FK_OVL, FK_SHORT: return GC_ALLOFF;
      FK_OVV:           return GC_CLAMP;
      default:          return GC_RUN;
    endcase
  endfunction
endpackage

// File: rtl/vfg_persist.sv
module vfg_persist #(
  parameter int DLY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flag,
  output logic hit
);
  localparam int CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt;

  assign hit = flag && (cnt == CW'(DLY - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || !flag) cnt <= '0;
    else if (!hit)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vfg_plane.sv
module vfg_plane
  import vr_fault_pkg::*;
#(
  parameter int OC_DLY = 16,
  parameter int SC_DLY = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        active,
  input  logic        oc,
  input  logic        sc,
  input  logic        ov,
  output fault_kind_t kind
);
  logic oc_hit, sc_hit;
  fault_kind_t kind_d;

  vfg_persist #(.DLY(OC_DLY)) u_ovl (
    .clk(clk), .rst(rst), .clr(!active), .flag(oc), .hit(oc_hit));
  vfg_persist #(.DLY(SC_DLY)) u_short (
    .clk(clk), .rst(rst), .clr(!active), .flag(sc), .hit(sc_hit));

  always_comb begin
    kind_d = kind;
    if (!active)               kind_d = FK_NONE;
    else if (kind == FK_NONE) begin
      if (ov)                  kind_d = FK_OVV;
      else if (sc_hit)         kind_d = FK_SHORT;
      else if (oc_hit)         kind_d = FK_OVL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) kind <= FK_NONE;
    else     kind <= kind_d;
  end
endmodule

// File: rtl/vfg_pgood.sv
module vfg_pgood #(
  parameter int NPL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [NPL-1:0]   faulted,
  input  logic [NPL-1:0]   plane_on,
  input  logic [NPL-1:0]   win_hi,
  input  logic [NPL-1:0]   win_lo,
  output logic             pgood
);
  logic [NPL-1:0] plane_ok;

  for (genvar p = 0; p < NPL; p++) begin : g_ok
    assign plane_ok[p] = !faulted[p] && (!plane_on[p] || (!win_hi[p] && !win_lo[p]));
  end

  always_ff @(posedge clk) begin
    if (rst) pgood <= 1'b0;
    else     pgood <= active && (&plane_ok);
  end
endmodule

// File: rtl/vr_fault_guard.sv
module vr_fault_guard
  import vr_fault_pkg::*;
#(
  parameter int NPL    = 2,
  parameter int OC_DLY = 10000,
  parameter int SC_DLY = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_ok,
  input  logic             en,
  input  logic [NPL-1:0]   oc_flag,
  input  logic [NPL-1:0]   sc_flag,
  input  logic [NPL-1:0]   ov_flag,
  input  logic [NPL-1:0]   win_hi,
  input  logic [NPL-1:0]   win_lo,
  input  logic [NPL-1:0]   plane_on,
  output logic [2*NPL-1:0] gate_ovr,
  output logic [2*NPL-1:0] fault_kind,
  output logic             pgood
);
  logic active;
  logic [NPL-1:0] faulted;

  assign active = por_ok && en;

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    fault_kind_t k;
    vfg_plane #(.OC_DLY(OC_DLY), .SC_DLY(SC_DLY)) u_plane (
      .clk(clk), .rst(rst), .active(active),
      .oc(oc_flag[p]), .sc(sc_flag[p]), .ov(ov_flag[p]), .kind(k));
    assign fault_kind[2*p +: 2] = k;
    assign gate_ovr[2*p +: 2]   = kind_to_gate(k, active && !rst);
    assign faulted[p]           = (k != FK_NONE);
  end

  vfg_pgood #(.NPL(NPL)) u_pg (
    .clk(clk), .rst(rst), .active(active), .faulted(faulted),
    .plane_on(plane_on), .win_hi(win_hi), .win_lo(win_lo), .pgood(pgood));
endmodule

// File: rtl/vr_fault_guard_chk.sv
module vr_fault_guard_chk #(
  parameter int NPL = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             por_ok,
  input logic             en,
  input logic [NPL-1:0]   ov_flag,
  input logic [2*NPL-1:0] gate_ovr,
  input logic [2*NPL-1:0] fault_kind,
  input logic             pgood
);
  for (genvar p = 0; p < NPL; p++) begin : g_chk
    assert_ov_latch_R5: assert property (@(posedge clk) disable iff (rst)
      (por_ok && en && ov_flag[p] && fault_kind[2*p +: 2] == 2'd0)
        |=> fault_kind[2*p +: 2] == 2'd3);
    assert_kind_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (por_ok && en && fault_kind[2*p +: 2] != 2'd0) |=> $stable(fault_kind[2*p +: 2]));
    assert_fault_drops_pg_R10: assert property (@(posedge clk) disable iff (rst)
      (fault_kind[2*p +: 2] != 2'd0) |=> !pgood);
    assert_gate_legal_R6: assert property (@(posedge clk) disable iff (rst)
      gate_ovr[2*p +: 2] != 2'd3);
  end
  assert_off_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !(por_ok && en) |=> (fault_kind == '0 && !pgood));
endmodule

bind vr_fault_guard vr_fault_guard_chk #(.NPL(NPL)) u_chk (
  .clk(clk), .rst(rst), .por_ok(por_ok), .en(en), .ov_flag(ov_flag),
  .gate_ovr(gate_ovr), .fault_kind(fault_kind), .pgood(pgood));

// File: tb/test_vr_fault_guard.sv
module test_vr_fault_guard;
  localparam int NPL = 2;
  localparam int OCD = 10000;
  localparam int SCD = 2000;

  logic clk = 0, rst = 1, por_ok = 0, en = 0;
  logic [NPL-1:0] oc_flag = 0, sc_flag = 0, ov_flag = 0;
  logic [NPL-1:0] win_hi = 0, win_lo = 0, plane_on = 2'b11;
  logic [2*NPL-1:0] gate_ovr, fault_kind;
  logic pgood;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  vr_fault_guard #(.NPL(NPL), .OC_DLY(OCD), .SC_DLY(SCD)) i_vr_fault_guard (
    .clk(clk), .rst(rst), .por_ok(por_ok), .en(en), .oc_flag(oc_flag),
    .sc_flag(sc_flag), .ov_flag(ov_flag), .win_hi(win_hi), .win_lo(win_lo),
    .plane_on(plane_on), .gate_ovr(gate_ovr), .fault_kind(fault_kind), .pgood(pgood));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    oc_flag = 0; sc_flag = 0; ov_flag = 0; win_hi = 0; win_lo = 0; plane_on = 2'b11;
    en = 0; step(2); en = 1; step(2);
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 kind in reset", fault_kind, 4'h0);
    chk("R1 gate in reset", gate_ovr, 4'b0101);
    chk("R1 pgood in reset", pgood, 0);
    rst = 0; step(2);
    chk("R1 gate while disabled", gate_ovr, 4'b0101);
    por_ok = 1; en = 1; step(2);
    chk("R6 gate running", gate_ovr, 4'h0);
    chk("R10 pgood up", pgood, 1);
  endtask

  task automatic t_overload();
    oc_flag[0] = 1; step(OCD - 1);
    chk("R2 no latch at OC_DLY-1", fault_kind, 4'h0);
    step(1);
    chk("R2 overload latched", fault_kind, 4'h1);
    chk("R6 core all off", gate_ovr, 4'b0001);
    chk("R7 nb untouched", gate_ovr[3:2], 2'd0);
    step(1);
    chk("R10 pgood drops on fault", pgood, 0);
    oc_flag[0] = 0; step(5);
    chk("R8 latch holds after flag drops", fault_kind, 4'h1);
    ov_flag[0] = 1; step(3);
    chk("R8 first kind kept", fault_kind, 4'h1);
    ov_flag[0] = 0;
    en = 0; step(1);
    chk("R9 clear on en low", fault_kind, 4'h0);
    en = 1; step(2);
    chk("R9 fault-free after re-enable", fault_kind, 4'h0);
    chk("R9 pgood back", pgood, 1);
  endtask

  task automatic t_restart();
    oc_flag[0] = 1; step(OCD - 1);
    oc_flag[0] = 0; step(1);
    oc_flag[0] = 1; step(OCD - 1);
    chk("R3 count restarted", fault_kind, 4'h0);
    step(1);
    chk("R3 latch after full window", fault_kind, 4'h1);
    restart();
  endtask

  task automatic t_short();
    sc_flag[1] = 1; step(SCD - 1);
    chk("R4 no latch early", fault_kind, 4'h0);
    step(1);
    chk("R4 short latched on nb", fault_kind, 4'h8);
    chk("R7 core gate unaffected", gate_ovr, 4'b0100);
    restart();
  endtask

  task automatic t_ovv();
    ov_flag[0] = 1; step(1);
    chk("R5 overvoltage immediate", fault_kind, 4'h3);
    chk("R6 clamp code", gate_ovr, 4'b0010);
    restart();
    oc_flag[1] = 1; sc_flag[1] = 1; ov_flag[1] = 1; step(1);
    chk("R8 priority overvoltage", fault_kind, 4'hC);
    oc_flag[1] = 0; sc_flag[1] = 0; ov_flag[1] = 0;
    restart();
  endtask

  task automatic t_window();
    win_hi[0] = 1; step(1);
    chk("R10 pgood low above window", pgood, 0);
    win_hi[0] = 0; win_lo[1] = 1; step(1);
    chk("R10 pgood low below window", pgood, 0);
    plane_on[1] = 0; step(1);
    chk("R11 off plane ignored", pgood, 1);
    win_lo[1] = 0; win_hi[1] = 1; step(1);
    chk("R11 off plane ignored hi", pgood, 1);
    por_ok = 0; step(1);
    chk("R1 pgood low without por", pgood, 0);
    chk("R1 gate off without por", gate_ovr, 4'b0101);
    por_ok = 1;
    restart();
  endtask

  initial begin
    t_reset();
    t_overload();
    t_restart();
    t_short();
    t_ovv();
    t_window();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule